// File: doc/BRIEF.md
# Half-Duplex Transmit MAC with Collision Backoff

This block is the transmit engine of one Ethernet port on a 50 MHz reduced-pin interface. It drives one two-bit symbol per clock. It reads the frame byte by byte from a buffer that the block addresses. The buffer returns the byte combinationally. The frame already carries its FCS. The block sends the preamble and start delimiter first, then the frame bytes, least significant dibit first. It holds a programmable inter-frame gap before every attempt. In half duplex, carrier sense holds back the start of transmission.

In half duplex, a collision makes the block stop the frame and send a jam. An early collision leads to a truncated binary exponential backoff and a retry from the first preamble dibit. A late collision, or a sixteenth collision, drops the frame. At the end of every frame the block gives a one-cycle completion pulse and a release flag. The buffer frees the frame on that flag: it is high only when an attempt finished with no collision. In full duplex the carrier and collision inputs have no effect.

Top module: `mac_tx_hd`

## Requirements
- R1: TXEN rises with the first preamble dibit and stays high without a break. The line carries 31 dibits of 01, then one dibit of 11, then every frame byte in address order. Each byte is sent as four dibits: bits [1:0] first, then [3:2], [5:4] and [7:6].
- R2: On a clean attempt TXEN is high for exactly 32 + 4*length cycles. It is low in the cycle after the last dibit. In that same cycle done pulses with the release flag set.
- R3: TXD is 00 in every cycle in which TXEN is low.
- R4: At least IFG_CYC idle cycles come before every attempt. In half duplex, carrier sense restarts the gap, so the first preamble dibit appears exactly IFG_CYC clocks after carrier drops.
- R5: In half duplex, a collision sampled while TXEN is high is answered from the next cycle on. The block sends JAM_CYC dibits of 01, then TXEN goes low.
- R6: After the jam of early collision number n, TXEN stays low for exactly 1 + r*SLOT_CYC + IFG_CYC cycles, where 0 <= r <= 2^min(n, BO_LIMIT) - 1. The retry then starts again with the preamble and byte 0.
- R7: A collision is late when it is sampled at dibit index LATE_DIBITS or beyond, counting from 0 at the first preamble dibit. A late collision is jammed and then ends the frame: done pulses with the release flag low, and there is no retry.
- R8: If the MAX_ATTEMPTS-th attempt also collides, the frame ends after its jam with the release flag low. If that attempt is clean, the frame is released.
- R9: In full duplex the collision and carrier inputs are ignored. The frame goes out in one clean attempt and is released.
- R10: The release flag is high only at the end of an attempt that had no collision.
- R11: During reset and right after it, TXEN, TXD and done are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock, one dibit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| full_duplex_i | input | 1 | 1 = full duplex; carrier and collision are ignored |
| crs_i | input | 1 | Carrier sense from the PHY |
| col_i | input | 1 | Collision indication from the PHY |
| frame_valid_i | input | 1 | A frame is waiting in the buffer; held until done |
| frame_len_i | input | LEN_W | Frame length in bytes, FCS included, at least 1 |
| rd_addr_o | output | LEN_W | Byte index read from the buffer |
| rd_data_i | input | 8 | Buffer byte at rd_addr_o, combinational |
| txen_o | output | 1 | Transmit enable |
| txd_o | output | 2 | Transmit dibit |
| done_o | output | 1 | One-cycle pulse: the frame is finished |
| done_ok_o | output | 1 | Qualifies done_o: 1 = free the frame, 0 = dropped |

## Verification
Two states are hard to reach from the ports. The first is the exact edge between early and late collisions. The second is a run of sixteen back-to-back collisions on one frame. The bench asserts collision at a chosen dibit index in each of the first N attempts. It places the index at 255, 256 and inside the preamble. It builds the block with a short slot time, so that backoffs of up to 1023 slots stay short. Backoff values come from an internal generator, so the bench does not predict them. For each gap it checks that the length is a whole number of slots, and that the slot count stays inside the window for that attempt.

// File: rtl/mac_tx_pkg.sv
package mac_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_IFG,
    S_PRE,
    S_DATA,
    S_JAM,
    S_BACKOFF
  } state_e;

  localparam int          PRE_DIBITS = 32;
  localparam logic [1:0]  PRE_DIBIT  = 2'b01;
  localparam logic [1:0]  SFD_DIBIT  = 2'b11;
  localparam logic [1:0]  JAM_DIBIT  = 2'b01;
endpackage

// File: rtl/mac_tx_lfsr.sv
module mac_tx_lfsr #(
  parameter int          W     = 16,
  parameter int          OUT_W = 10,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED[W-1:0];
    else         q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS[W-1:0] : '0);
  end

  assign rnd_o = q[OUT_W-1:0] ^ q[W-1 -: OUT_W];
endmodule

// File: rtl/mac_tx_backoff.sv
module mac_tx_backoff #(
  parameter int SLOT_CYC = 256,
  parameter int LIMIT    = 10,
  parameter int ATT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [ATT_W-1:0] coll_num_i,
  input  logic [LIMIT-1:0] rnd_i,
  output logic             expired_o
);
  localparam int             SUB_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOT_CYC - 1);

  logic [LIMIT-1:0] mask;
  logic [LIMIT-1:0] slots_q;
  logic [SUB_W-1:0] sub_q;

  // window = 2^min(n, LIMIT) - 1
  for (genvar g = 0; g < LIMIT; g++) begin : g_mask
    assign mask[g] = (32'(coll_num_i) > g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q <= '0;
      sub_q   <= '0;
    end else if (load_i) begin
      slots_q <= rnd_i & mask;
      sub_q   <= '0;
    end else if (run_i && slots_q != '0) begin
      if (sub_q == SUB_LAST) begin
        sub_q   <= '0;
        slots_q <= slots_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign expired_o = (slots_q == '0);

  assert_slot_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !expired_o && sub_q != SUB_LAST) |=> $stable(slots_q));
endmodule

// File: rtl/mac_tx_dibit_sel.sv
module mac_tx_dibit_sel
  import mac_tx_pkg::*;
(
  input  state_e     st_i,
  input  logic       last_pre_i,
  input  logic [7:0] byte_i,
  input  logic [1:0] dib_i,
  output logic       txen_o,
  output logic [1:0] txd_o
);
  always_comb begin
    txen_o = 1'b0;
    txd_o  = 2'b00;
    unique case (st_i)
      S_PRE: begin
        txen_o = 1'b1;
        txd_o  = last_pre_i ? SFD_DIBIT : PRE_DIBIT;
      end
      S_DATA: begin
        txen_o = 1'b1;
        txd_o  = byte_i[{dib_i, 1'b0} +: 2];
      end
      S_JAM: begin
        txen_o = 1'b1;
        txd_o  = JAM_DIBIT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_tx_hd.sv
module mac_tx_hd
  import mac_tx_pkg::*;
#(
  parameter int          LEN_W        = 11,
  parameter int          SLOT_CYC     = 256,
  parameter int          IFG_CYC      = 48,
  parameter int          JAM_CYC      = 16,
  parameter int          LATE_DIBITS  = 256,
  parameter int          BO_LIMIT     = 10,
  parameter int          MAX_ATTEMPTS = 16,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_duplex_i,
  input  logic             crs_i,
  input  logic             col_i,
  input  logic             frame_valid_i,
  input  logic [LEN_W-1:0] frame_len_i,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             txen_o,
  output logic [1:0]       txd_o,
  output logic             done_o,
  output logic             done_ok_o
);
  localparam int CMAX_A = (IFG_CYC > JAM_CYC) ? IFG_CYC : JAM_CYC;
  localparam int CMAX   = (CMAX_A > PRE_DIBITS) ? CMAX_A : PRE_DIBITS;
  localparam int CNT_W  = $clog2(CMAX) + 1;
  localparam int ATT_W  = $clog2(MAX_ATTEMPTS + 1);
  localparam int SENT_W = LEN_W + 3;

  localparam logic [CNT_W-1:0]  IFG_LAST = CNT_W'(IFG_CYC - 1);
  localparam logic [CNT_W-1:0]  PRE_LAST = CNT_W'(PRE_DIBITS - 1);
  localparam logic [CNT_W-1:0]  JAM_LAST = CNT_W'(JAM_CYC - 1);
  localparam logic [ATT_W-1:0]  ATT_LAST = ATT_W'(MAX_ATTEMPTS - 1);
  localparam logic [SENT_W-1:0] LATE_V   = SENT_W'(LATE_DIBITS);

  state_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  pos_q;
  logic [1:0]        dib_q;
  logic [SENT_W-1:0] sent_q;
  logic [ATT_W-1:0]  att_q;
  logic              late_q, done_q, ok_q;

  logic              coll, defer, jam_last, bo_load, bo_expired;
  logic [BO_LIMIT-1:0] rnd;

  assign coll     = col_i & ~full_duplex_i;
  assign defer    = crs_i & ~full_duplex_i;
  assign jam_last = (st_q == S_JAM) && (cnt_q == JAM_LAST);
  assign bo_load  = jam_last && !late_q && (att_q != ATT_LAST);

  mac_tx_lfsr #(
    .W     (16),
    .OUT_W (BO_LIMIT),
    .SEED  (LFSR_SEED)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd)
  );

  mac_tx_backoff #(
    .SLOT_CYC (SLOT_CYC),
    .LIMIT    (BO_LIMIT),
    .ATT_W    (ATT_W)
  ) u_backoff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (bo_load),
    .run_i      (st_q == S_BACKOFF),
    .coll_num_i (att_q + 1'b1),
    .rnd_i      (rnd),
    .expired_o  (bo_expired)
  );

  mac_tx_dibit_sel u_sel (
    .st_i       (st_q),
    .last_pre_i (cnt_q == PRE_LAST),
    .byte_i     (rd_data_i),
    .dib_i      (dib_q),
    .txen_o     (txen_o),
    .txd_o      (txd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      pos_q  <= '0;
      dib_q  <= '0;
      sent_q <= '0;
      att_q  <= '0;
      late_q <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (frame_valid_i) begin
          st_q  <= S_IFG;
          cnt_q <= '0;
          att_q <= '0;
        end
        S_IFG: begin
          if (defer) cnt_q <= '0;
          else if (cnt_q == IFG_LAST) begin
            st_q   <= S_PRE;
            cnt_q  <= '0;
            sent_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_PRE, S_DATA: begin
          sent_q <= sent_q + 1'b1;
          if (coll) begin
            st_q   <= S_JAM;
            cnt_q  <= '0;
            late_q <= (sent_q >= LATE_V);
          end else if (st_q == S_PRE) begin
            if (cnt_q == PRE_LAST) begin
              st_q  <= S_DATA;
              pos_q <= '0;
              dib_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end else begin
            dib_q <= dib_q + 1'b1;
            if (dib_q == 2'd3) begin
              if (pos_q == frame_len_i - 1'b1) begin
                st_q   <= S_IDLE;
                done_q <= 1'b1;
                ok_q   <= 1'b1;
              end else pos_q <= pos_q + 1'b1;
            end
          end
        end
        S_JAM: begin
          if (cnt_q == JAM_LAST) begin
            if (late_q || att_q == ATT_LAST) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
              ok_q   <= 1'b0;
            end else begin
              st_q  <= S_BACKOFF;
              att_q <= att_q + 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_BACKOFF: if (bo_expired) begin
          st_q  <= S_IFG;
          cnt_q <= '0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_addr_o = pos_q;
  assign done_o    = done_q;
  assign done_ok_o = ok_q;

  assert_txd_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txen_o |-> txd_o == 2'b00);

  assert_txen_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txen_o) |-> ($past(st_q) == S_DATA || $past(st_q) == S_JAM));

  assert_fd_no_jam_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_duplex_i && st_q != S_JAM) |=> st_q != S_JAM);

  assert_late_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jam_last && late_q) |=> (done_o && !done_ok_o && !txen_o));

  assert_release_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_ok_o) |-> $past(st_q) == S_DATA);

  assert_attempt_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= ATT_LAST);
endmodule

// File: tb/tb_mac_tx_hd.sv
`timescale 1ns/1ps
module tb_mac_tx_hd;
  localparam int LEN_W    = 11;
  localparam int SLOT_CYC = 4;
  localparam int IFG_CYC  = 48;
  localparam int JAM_CYC  = 16;
  localparam int LATE     = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             full_dup = 1'b0, crs = 1'b0, col = 1'b0, fvalid = 1'b0;
  logic [LEN_W-1:0] flen = '0;
  logic [LEN_W-1:0] rd_addr;
  logic [7:0]       rd_data;
  logic             txen, done, done_ok;
  logic [1:0]       txd;
  logic [7:0]       mem [0:(1<<LEN_W)-1];

  assign rd_data = mem[rd_addr];

  mac_tx_hd #(.LEN_W(LEN_W), .SLOT_CYC(SLOT_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .full_duplex_i(full_dup), .crs_i(crs), .col_i(col),
    .frame_valid_i(fvalid), .frame_len_i(flen), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .txen_o(txen), .txd_o(txd), .done_o(done), .done_ok_o(done_ok));

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      chk(1'b0, "watchdog", cycles, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    int fd; int len; int col_at; int ncol; int ok; int att;
  } row_t;

  // fd, len, collision dibit index, colliding attempts, expected release, expected attempts
  localparam row_t ROWS [10] = '{
    '{0,  8,  -1,  0, 1,  1},  // R1 clean half duplex
    '{1, 20,  -1,  0, 1,  1},  // R1 clean full duplex
    '{0, 10,  40,  1, 1,  2},  // R5 R6 early collision in data
    '{0, 10,   5,  3, 1,  4},  // R5 R6 collisions in preamble
    '{0, 70, 300,  1, 0,  1},  // R7 late collision
    '{0, 70, 255,  1, 1,  2},  // R7 last early index
    '{0, 70, 256,  1, 0,  1},  // R7 first late index
    '{1, 12,  10,  5, 1,  1},  // R9 full duplex ignores collision
    '{0,  6,   3, 16, 0, 16},  // R8 excessive collisions
    '{0,  6,   3, 15, 1, 16}   // R8 success on final attempt
  };

  function automatic int exp_dibit(input int idx);
    if (idx < 31) return 1;
    if (idx == 31) return 3;
    return (mem[(idx-32)/4] >> (2*((idx-32)%4))) & 3;
  endfunction

  task automatic run_frame(input int fd, input int len, input int col_at, input int ncol,
                           input int exp_ok, input int exp_att, input string tag);
    int att = 0, idx = 0, jam = 0, low = 0, cidx = -1;
    bit got = 1'b0;
    full_dup = fd[0];
    flen = LEN_W'(len);
    fvalid = 1'b1;
    for (int c = 0; c < 150000 && !got; c++) begin
      @(negedge clk);
      col = 1'b0;
      if (txen) begin
        if (idx == 0) begin
          if (att == 0) chk(low >= IFG_CYC, "R4 first gap", low, IFG_CYC);
          else begin
            int bo   = low - 1 - IFG_CYC;
            int maxr = (1 << ((att < 10) ? att : 10)) - 1;
            chk(bo >= 0 && bo % SLOT_CYC == 0 && bo / SLOT_CYC <= maxr,
                "R6 backoff gap", low, 1 + IFG_CYC);
          end
          att++;
          low = 0;
          cidx = (fd == 0 && att <= ncol) ? col_at : -1;
        end
        if (cidx >= 0 && idx > cidx) begin
          jam++;
          chk(txd == 2'b01, "R5 jam dibit", txd, 1);
        end else begin
          chk(int'(txd) == exp_dibit(idx), "R1 dibit", txd, exp_dibit(idx));
        end
        if (att <= ncol && idx == col_at) col = 1'b1;
        idx++;
      end else begin
        if (idx > 0) begin
          if (cidx >= 0) chk(jam == JAM_CYC && idx == cidx + 1 + JAM_CYC, "R5 jam length", jam, JAM_CYC);
          else           chk(idx == 32 + 4*len, "R2 txen length", idx, 32 + 4*len);
          idx = 0;
          jam = 0;
        end
        low++;
        chk(txd == 2'b00, "R3 idle txd", txd, 0);
      end
      if (done) begin
        got = 1'b1;
        fvalid = 1'b0;
        chk(!txen, "R2 txen low at done", txen, 0);
        chk(int'(done_ok) == exp_ok, {tag, " release"}, done_ok, exp_ok);
        chk(att == exp_att, {tag, " attempts"}, att, exp_att);
      end
    end
    chk(got, {tag, " done seen"}, got, 1);
    @(negedge clk);
    chk(!done, "R2 done single pulse", done, 0);
    full_dup = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < (1<<LEN_W); i++) mem[i] = 8'((i * 37 + 5) & 8'hFF);
    repeat (3) @(negedge clk);
    chk(!txen && txd == 2'b00 && !done, "R11 in reset", {txen, txd, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!txen && txd == 2'b00 && !done, "R11 after reset", {txen, txd, done}, 0);

    for (int r = 0; r < 10; r++) begin
      for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + r * 11 + 5) & 8'hFF);
      run_frame(ROWS[r].fd, ROWS[r].len, ROWS[r].col_at, ROWS[r].ncol,
                ROWS[r].ok, ROWS[r].att, (r == 4 || r == 6) ? "R7" :
                (r == 7) ? "R9" : (r >= 8) ? "R8" : "R10");
      repeat (4) @(negedge clk);
    end

    // R4: carrier defers the start; preamble appears IFG_CYC clocks after carrier drops
    begin
      int low = 0;
      crs = 1'b1;
      flen = LEN_W'(4);
      fvalid = 1'b1;
      repeat (100) @(negedge clk);
      chk(!txen, "R4 defer while carrier", txen, 0);
      crs = 1'b0;
      @(negedge clk);
      while (!txen && low < 500) begin
        low++;
        @(negedge clk);
      end
      chk(low == IFG_CYC - 1, "R4 gap after carrier", low + 1, IFG_CYC);
      while (!done) @(negedge clk);
      chk(done_ok, "R4 release after defer", done_ok, 1);
      fvalid = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R9: carrier held high in full duplex does not defer
    begin
      int low = 0;
      full_dup = 1'b1;
      crs = 1'b1;
      flen = LEN_W'(4);
      fvalid = 1'b1;
      while (!txen && low < 500) begin
        @(negedge clk);
        low++;
      end
      chk(low == IFG_CYC + 1, "R9 no defer in full duplex", low, IFG_CYC + 1);
      while (!done) @(negedge clk);
      chk(done_ok, "R9 release in full duplex", done_ok, 1);
      fvalid = 1'b0;
      crs = 1'b0;
      full_dup = 1'b0;
      repeat (4) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule